// File: doc/BRIEF.md
# Packed 64-bit Integer Add and Word Shuffle Unit

This execution unit works on 64-bit packed integer operands. Each issued operation takes two 64-bit sources, an 8-bit control immediate and an operation code. One clock later it returns a 64-bit result together with a valid strobe. The unit supports four operations. Lane-wise wrapping addition works on 16-bit words or on 32-bit doublewords. Lane-wise signed saturating addition works on 16-bit words. A word permute picks each of the four result words from the words of the second source. A fifth code passes the second source through unchanged, which serves register-to-register moves.

The unit issues once per cycle with no stall. A new valid input may arrive on every clock. The operand register file, memory operand fetch and the wider move path sit outside the unit. Bits are numbered with word 0 at bits 15:0 and word 3 at bits 63:48. Doubleword 0 is bits 31:0.

Top module: `simd_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` goes low and `out_data` goes to zero after that edge.
- R2: `out_valid` is high after a rising edge exactly when `in_valid` was high at that edge. Back-to-back valid inputs each give their own result one cycle later.
- R3: With `op_sel` = 3, each 16-bit lane gets the signed sum of `src_a` and `src_b`, clamped to 0x7FFF when both inputs are non-negative and the true sum exceeds it, and to 0x8000 when both are negative and the true sum is below it.
- R4: With `op_sel` = 1, each 16-bit lane gets `src_a` + `src_b` modulo 2^16, and no carry passes from one lane to the next.
- R5: With `op_sel` = 2, each 32-bit lane gets `src_a` + `src_b` modulo 2^32. Carries cross bit 15 to bit 16 but never cross bit 31 to bit 32.
- R6: With `op_sel` = 4, result word i equals word number `imm[2i+1:2i]` of `src_b`, for i = 0..3. `src_a` has no effect.
- R7: With `op_sel` = 0, and for the unused codes 5, 6 and 7, the result equals `src_b`, and `src_a` and `imm` have no effect.
- R8: After a rising edge where `in_valid` was low and `rst` was low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| op_sel | input | 3 | Operation code (0 pass, 1 word add, 2 doubleword add, 3 saturating word add, 4 shuffle) |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand (shuffle and pass source) |
| imm | input | 8 | Shuffle control, two select bits per result word |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_data | output | 64 | Registered packed result |

## Verification
The clocked properties assume that `op_sel`, `src_a`, `src_b` and `imm` are steady at each sampling edge. Every check compares the registered output with the inputs sampled one edge earlier. The bench meets this by changing every input on the falling clock edge only. It reads results at the following falling edge, so each operand set is stable across exactly one rising edge. Reset is raised only between operations, apart from one test where it collides with a valid issue, and the properties that depend on it are disabled during reset.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_ADDW  = 3'd1,
    OP_ADDD  = 3'd2,
    OP_ADDSW = 3'd3,
    OP_SHUF  = 3'd4
  } simd_op_e;

  localparam int OP_W = 3;

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat_en,
  output logic [W-1:0] sum
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         pos_ovf;
  logic         neg_ovf;

  always_comb begin
    raw     = a + b;
    // overflow: operands share a sign that the wrapped sum lost
    pos_ovf = !a[W-1] && !b[W-1] &&  raw[W-1];
    neg_ovf =  a[W-1] &&  b[W-1] && !raw[W-1];
    if (sat_en && pos_ovf)      sum = MAX_POS;
    else if (sat_en && neg_ovf) sum = MIN_NEG;
    else                        sum = raw;
  end

endmodule

// File: rtl/simd_word_shuffle.sv
module simd_word_shuffle #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16
) (
  input  logic [DATA_W-1:0]                           src,
  input  logic [(DATA_W/WORD_W)*$clog2(DATA_W/WORD_W)-1:0] sel,
  output logic [DATA_W-1:0]                           dst
);

  localparam int NW    = DATA_W / WORD_W;
  localparam int SEL_W = $clog2(NW);

  always_comb begin
    dst = '0;
    for (int i = 0; i < NW; i++) begin
      dst[i*WORD_W +: WORD_W] = src[int'(sel[i*SEL_W +: SEL_W])*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int DWORD_W = 2 * WORD_W;
  localparam int NW      = DATA_W / WORD_W;
  localparam int ND      = DATA_W / DWORD_W;
  localparam int SHUF_W  = NW * $clog2(NW);

  simd_op_e          op;
  logic              is_sat;
  logic [DATA_W-1:0] word_sum;
  logic [DATA_W-1:0] dword_sum;
  logic [DATA_W-1:0] shuf_out;
  logic [DATA_W-1:0] result;

  assign op     = simd_op_e'(op_sel);
  assign is_sat = (op == OP_ADDSW);

  // word lanes: one adder per lane, saturation chosen per operation
  generate
    for (genvar g = 0; g < NW; g++) begin : g_word
      simd_lane_add #(.W(WORD_W)) u_add (
        .a      (src_a[g*WORD_W +: WORD_W]),
        .b      (src_b[g*WORD_W +: WORD_W]),
        .sat_en (is_sat),
        .sum    (word_sum[g*WORD_W +: WORD_W])
      );
    end
    for (genvar g = 0; g < ND; g++) begin : g_dword
      simd_lane_add #(.W(DWORD_W)) u_add (
        .a      (src_a[g*DWORD_W +: DWORD_W]),
        .b      (src_b[g*DWORD_W +: DWORD_W]),
        .sat_en (1'b0),
        .sum    (dword_sum[g*DWORD_W +: DWORD_W])
      );
    end
  endgenerate

  simd_word_shuffle #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_shuf (
    .src (src_b),
    .sel (imm[SHUF_W-1:0]),
    .dst (shuf_out)
  );

  always_comb begin
    case (op)
      OP_ADDW, OP_ADDSW: result = word_sum;
      OP_ADDD:           result = dword_sum;
      OP_SHUF:           result = shuf_out;
      default:           result = src_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  // R1: reset empties the output stage
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R2: valid follows issue by exactly one cycle
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: two non-negative lane-0 inputs never yield a negative lane-0 result
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_ADDSW && !src_a[WORD_W-1] && !src_b[WORD_W-1])
      |=> !out_data[WORD_W-1]);

  // R5: low doubleword equals the modular sum of the sampled operands
  p_dword_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_ADDD)
      |=> out_data[DWORD_W-1:0] == $past(src_a[DWORD_W-1:0] + src_b[DWORD_W-1:0]));

  // R7: pass code returns the second source
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_PASS) |=> out_data == $past(src_b));

  // R8: idle cycles leave the result register untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

endmodule

// File: tb/simd_exec_unit_tb.sv
module simd_exec_unit_tb;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  imm;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R4 word add, simple
    '{3'd1, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, 8'h00, 64'h0011_0022_0033_0044},
    // R4 wrap in every lane, no carry between lanes
    '{3'd1, 64'hFFFF_8000_7FFF_0001, 64'h0001_8000_0001_FFFF, 8'h00, 64'h0000_0000_8000_0000},
    // R5 carry across bit 15 but not bit 31
    '{3'd2, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 8'h00, 64'h0001_0000_0000_0000},
    '{3'd2, 64'h1234_5678_0000_8000, 64'h1111_1111_0000_8000, 8'h00, 64'h2345_6789_0001_0000},
    // R3 saturation both directions, plain lanes
    '{3'd3, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_0001_0001, 8'h00, 64'h7FFF_8000_1235_0000},
    '{3'd3, 64'h4000_C000_7000_8001, 64'h4000_C000_9000_8001, 8'h00, 64'h7FFF_8000_0000_8000},
    // R6 shuffles
    '{3'd4, 64'hDEAD_BEEF_DEAD_BEEF, 64'h4444_3333_2222_1111, 8'h1B, 64'h1111_2222_3333_4444},
    '{3'd4, 64'h0000_0000_0000_0000, 64'h4444_3333_2222_1111, 8'h00, 64'h1111_1111_1111_1111},
    '{3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4444_3333_2222_1111, 8'hE4, 64'h4444_3333_2222_1111},
    '{3'd4, 64'h1234_1234_1234_1234, 64'h4444_3333_2222_1111, 8'h9C, 64'h3333_2222_4444_1111},
    // R7 pass and an unused code
    '{3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 8'h5A, 64'h0123_4567_89AB_CDEF},
    '{3'd7, 64'h5555_5555_5555_5555, 64'hCAFE_F00D_1234_5678, 8'hFF, 64'hCAFE_F00D_1234_5678}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  imm = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  simd_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // independent model of the requirements
  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [7:0] im);
    logic [63:0] r;
    int s;
    r = b;
    if (op == 3'd1) begin
      for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'(a[i*16 +: 16] + b[i*16 +: 16]);
    end else if (op == 3'd2) begin
      for (int i = 0; i < 2; i++) r[i*32 +: 32] = 32'(a[i*32 +: 32] + b[i*32 +: 32]);
    end else if (op == 3'd3) begin
      for (int i = 0; i < 4; i++) begin
        s = int'($signed(a[i*16 +: 16])) + int'($signed(b[i*16 +: 16]));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[i*16 +: 16] = 16'(s);
      end
    end else if (op == 3'd4) begin
      for (int i = 0; i < 4; i++) r[i*16 +: 16] = b[int'(im[i*2 +: 2])*16 +: 16];
    end
    return r;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // issue one operation, then read the result a cycle later
  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] im);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [63:0] last;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 valid in reset", out_valid, 1'b0);
    check64("R1 data in reset", out_data, 64'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].op, VEC[k].a, VEC[k].b, VEC[k].imm);
      check1("R2 valid after issue", out_valid, 1'b1);
      check64(tag_of(VEC[k].op), out_data, VEC[k].exp);
    end

    // R2 and R8: idle cycle with changed inputs leaves the result alone
    last = out_data;
    op_sel = 3'd1; src_a = 64'h1111_1111_1111_1111; src_b = 64'h2222_2222_2222_2222;
    @(negedge clk);
    check1("R2 no valid when idle", out_valid, 1'b0);
    check64("R8 data held when idle", out_data, last);

    // R2: back-to-back issues, each checked against the model
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a;
      logic [63:0] b;
      logic [2:0]  op;
      logic [7:0]  im;
      a  = {32'(k * 32'h9E37_79B9), 32'(k * 32'h85EB_CA6B) ^ 32'h8000_7FFF};
      b  = {32'(k * 32'hC2B2_AE35) ^ 32'h7FFF_8000, 32'(k * 32'h27D4_EB2F)};
      op = 3'(k % 8);
      im = 8'(k * 37);
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
      @(negedge clk);
      check1("R2 back-to-back valid", out_valid, 1'b1);
      check64(tag_of(op), out_data, model(op, a, b, im));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check1("R2 valid drops after burst", out_valid, 1'b0);

    // R3: exact boundary sums that must not clamp
    issue(3'd3, 64'h7FFE_8001_0000_C000, 64'h0001_FFFF_0000_C000, 8'h00);
    check64("R3 exact limits", out_data, 64'h7FFF_8000_0000_8000);

    // R1: reset colliding with a valid issue wins
    @(negedge clk);
    op_sel = 3'd0; src_b = 64'hFFFF_0000_FFFF_0000; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check1("R1 reset beats issue", out_valid, 1'b0);
    check64("R1 reset clears data", out_data, 64'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule